// File: doc/BRIEF.md
# Paged I2C Memory Slave

This block is the serial front end of a 512-byte non-volatile store with a separate system register space. It watches a two-wire bus (clock and open-drain data, both brought in as plain inputs and synchronised to the local clock), recognises START and STOP, matches its device address, takes a two-byte memory address and then either collects write data or streams read data. The memory itself sits outside the block behind a simple synchronous port. The read data is registered and appears one clock after the address.

Writes collect in a small page buffer. The block commits that buffer to memory only when the master ends the transfer with STOP. It then runs a write cycle of a parameterised length. During that cycle it refuses every new addressing attempt, so the master can poll for completion. Reads start at the internal address pointer. They can follow a repeated START after the address bytes, and they continue byte by byte while the master acknowledges. A lock mask input blocks writes to whole user sectors.

Top module: `i2c_paged_eeprom_slave`

## Requirements
- R1: The slave acknowledges a device address byte only when its bits 7..4 are 1010 and bits 2..1 are 11. Bit 0 is the direction (1 = read). Any other address byte is not acknowledged, and the slave then ignores the bus until the next START.
- R2: Bit 3 of the device address selects the space: 0 selects user memory and 1 selects system memory. The choice appears on `mem_sys` for every memory access of the transfer.
- R3: Two address bytes follow a write-direction device address. Only bit 0 of the first byte is used, as address bit 8. Its bits 7..1 have no effect. The second byte gives address bits 7..0.
- R4: In a write, each acknowledged data byte enters a 4-byte page buffer at the pointer offset. The offset then advances modulo 4 inside the page, so a fifth byte overwrites the first. On STOP, one commit writes every loaded byte of that page to memory.
- R5: From the STOP that starts a commit until WR_CYCLES clocks after the last memory write, `busy` is high. In that time the slave acknowledges no device address and never pulls SDA low.
- R6: A read returns the byte at the pointer and then increments it. The pointer wraps from 511 to 0. A read without address bytes starts where the previous access left the pointer, and a write advances the pointer only within its page.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R8: Bit k of `lock_mask` locks user addresses 128k..128k+127. A data byte aimed at a locked user sector is not acknowledged and is never written. System space is never locked.
- R9: The slave samples SDA on rising SCL. It starts pulling SDA low only while SCL is low, after a falling edge.
- R10: A repeated START followed by a read-direction device address, sent right after the two address bytes, reads from the address just loaded.
- R11: A STOP that follows the address bytes with no data byte starts no commit, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_sys | output | 1 | 1 selects the system space |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after the address |
| lock_mask | input | 2**SECT_W | Per-sector write lock for user space |
| busy | output | 1 | Commit or write cycle in progress |

## Verification
The assertions rely on the bus moving slowly compared to `clk`. Every SCL and SDA level has to last several local clocks, so that the two-stage synchroniser and the edge detector see each change, and SDA may change only while SCL is low, except for START and STOP. The bench holds every bus phase for eight local clocks and moves the data line only in the low phase of SCL or in the START and STOP patterns. It also keeps the lock mask constant during each transfer. The bench memory model answers with a one-clock registered read, which is the timing the read path relies on when it loads a byte.

// File: rtl/i2c_paged_eeprom_slave.sv
module i2c_paged_eeprom_slave #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 2,
  parameter int SECT_W    = 2,
  parameter int WR_CYCLES = 1000,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_sys,
  output logic                   mem_we,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  input  logic [2**SECT_W-1:0]   lock_mask,
  output logic                   busy
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  st_t st;
  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pval, cm_val;
  logic cm_act;
  logic [PAGE_W-1:0] cm_idx;
  logic [ADDR_W-PAGE_W-1:0] cm_base;
  logic [CNT_W-1:0] timer;
  logic sys, oe;

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [SECT_W-1:0] sect = ptr[ADDR_W-1 -: SECT_W];
  wire locked   = ~sys & lock_mask[sect];
  wire dev_ok   = (shreg[7:4] == DEV_ID) && (shreg[2:1] == 2'b11) && !busy;

  assign busy      = cm_act | (timer != '0);
  assign sda_oe    = oe;
  assign mem_sys   = sys;
  assign mem_addr  = cm_act ? {cm_base, cm_idx} : ptr;
  assign mem_we    = cm_act & cm_val[cm_idx];
  assign mem_wdata = pbuf[cm_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= '1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; shreg <= '0; txreg <= '0; ptr <= '0;
      pval <= '0; cm_val <= '0; cm_act <= 1'b0; cm_idx <= '0; cm_base <= '0;
      timer <= '0; sys <= 1'b0; oe <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      if (cm_act) begin
        cm_idx <= cm_idx + 1'b1;
        if (cm_idx == PAGE_W'(PAGE - 1)) begin
          cm_act <= 1'b0;
          timer  <= CNT_W'(WR_CYCLES);
        end
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end

      if (start_c) begin
        st <= S_DEV; cnt <= '0; oe <= 1'b0; pval <= '0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; oe <= 1'b0;
        if (st == S_WR && |pval && !busy) begin
          cm_act  <= 1'b1;
          cm_idx  <= '0;
          cm_val  <= pval;
          cm_base <= ptr[ADDR_W-1:PAGE_W];
        end
        pval <= '0;
      end else if (scl_rise && st != S_IDLE) begin
        if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        if (cnt == 4'd8 && st == S_RD && sda_s) st <= S_IDLE;
        cnt <= cnt + 1'b1;
      end else if (scl_fall && st != S_IDLE) begin
        if (cnt == 4'd8) begin
          case (st)
            S_DEV: begin
              if (dev_ok) begin
                oe  <= 1'b1;
                sys <= shreg[3];
                st  <= shreg[0] ? S_RD : S_AHI;
              end else begin
                st <= S_IDLE;
              end
            end
            S_AHI: begin
              oe <= 1'b1;
              ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
              st <= S_ALO;
            end
            S_ALO: begin
              oe <= 1'b1;
              ptr[7:0] <= shreg;
              pval <= '0;
              st <= S_WR;
            end
            S_WR: begin
              if (locked) begin
                st <= S_IDLE;
              end else begin
                oe <= 1'b1;
                pbuf[ptr[PAGE_W-1:0]] <= shreg;
                pval[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              end
            end
            default: oe <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (st == S_RD) begin
            txreg <= {mem_rdata[6:0], 1'b0};
            oe    <= ~mem_rdata[7];
            ptr   <= ptr + 1'b1;
          end else begin
            oe <= 1'b0;
          end
        end else if (st == S_RD) begin
          oe    <= ~txreg[7];
          txreg <= {txreg[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2c_paged_eeprom_slave_chk.sv
module i2c_paged_eeprom_slave_chk #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r4_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r4_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

  a_r5_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_paged_eeprom_slave i2c_paged_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_i2c_paged_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_paged_eeprom_slave;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1;
  logic sda_oe, mem_sys, mem_we, busy;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] lock_mask = 4'b0000;
  wire line = m_sda & ~sda_oe;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] ref_m [0:1023];
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  i2c_paged_eeprom_slave #(.WR_CYCLES(300)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_sys(mem_sys), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .lock_mask(lock_mask), .busy(busy));

  always @(posedge clk) begin
    if (mem_we) mem[{mem_sys, mem_addr}] <= mem_wdata;
    mem_rdata <= mem[{mem_sys, mem_addr}];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic expect_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic hp; repeat (H) @(posedge clk); endtask

  task automatic i2c_start;
    m_sda = 1; hp; scl = 1; hp; m_sda = 0; hp; scl = 0; hp;
  endtask

  task automatic i2c_stop;
    m_sda = 0; hp; scl = 1; hp; m_sda = 1; hp; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp; scl = 1; hp; scl = 0;
    end
    m_sda = 1; hp; scl = 1;
    repeat (H/2) @(posedge clk);
    @(negedge clk) ack = ~line;
    repeat (H/2) @(posedge clk);
    scl = 0;
  endtask

  int unstable = 0;
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      logic first;
      hp; scl = 1;
      @(negedge clk) first = line;
      repeat (H - 1) @(posedge clk);
      @(negedge clk) b[i] = line;
      if (first != b[i]) unstable++;
      scl = 0;
    end
    m_sda = mack ? 1'b0 : 1'b1; hp; scl = 1; hp; scl = 0; hp;
    m_sda = 1;
    got_q.push_back(b);
  endtask

  task automatic poll_ready(output int tries);
    bit a;
    tries = 0;
    do begin
      i2c_start; send_byte(8'hA6, a); i2c_stop; tries++;
    end while (!a && tries < 50);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    int tries;
    logic [7:0] b;
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'(i) ^ 8'h3C; ref_m[i] = 8'(i) ^ 8'h3C; end
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sda_oe == 0 && busy == 0 && mem_we == 0, "R5 reset state", {sda_oe, busy, mem_we}, 0);

    // R1 address matching
    i2c_start; send_byte(8'hB6, a); i2c_stop;
    check(a == 0, "R1 wrong id nack", a, 0);
    i2c_start; send_byte(8'hA2, a); i2c_stop;
    check(a == 0, "R1 fixed bits nack", a, 0);

    // R11 STOP after address bytes
    i2c_start; send_byte(8'hA6, a);
    check(a == 1, "R1 match ack", a, 1);
    send_byte(8'h00, a); send_byte(8'h10, a); i2c_stop;
    repeat (10) @(negedge clk);
    check(busy == 0, "R11 no commit without data", busy, 0);

    // R3/R4 page write with wrap, high byte don't-care bits set
    i2c_start; send_byte(8'hA6, a); send_byte(8'hFE, a); send_byte(8'h22, a);
    check(a == 1, "R3 address ack", a, 1);
    for (int k = 0; k < 5; k++) begin
      send_byte(8'h11 * 8'(k + 1), a);
      check(a == 1, "R4 data ack", a, 1);
    end
    i2c_stop;
    repeat (6) @(negedge clk);
    check(busy == 1, "R5 busy after stop", busy, 1);
    ref_m[9'h020] = 8'h33; ref_m[9'h021] = 8'h44; ref_m[9'h022] = 8'h55; ref_m[9'h023] = 8'h22;
    poll_ready(tries);
    check(tries > 1, "R5 nack while busy", tries, 2);
    check(busy == 0, "R5 busy cleared", busy, 0);

    // R6 current address read: pointer at 0x023
    i2c_start; send_byte(8'hA7, a);
    expect_byte(ref_m[9'h023], "R6 current read");
    expect_byte(ref_m[9'h024], "R6 sequential next");
    recv_byte(1, b); recv_byte(0, b);
    check(sda_oe == 0, "R7 released after nack", sda_oe, 0);
    i2c_stop;

    // R10 selective read across the written page (R4 contents)
    i2c_start; send_byte(8'hA6, a); send_byte(8'h00, a); send_byte(8'h20, a);
    i2c_start; send_byte(8'hA7, a);
    check(a == 1, "R10 read after repeated start ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      expect_byte(ref_m[9'h020 + k], "R4 page content");
      recv_byte(k != 3, b);
    end
    i2c_stop;

    // R6 wrap at end of memory
    i2c_start; send_byte(8'hA6, a); send_byte(8'h01, a); send_byte(8'hFF, a);
    i2c_start; send_byte(8'hA7, a);
    expect_byte(ref_m[511], "R6 last byte");
    expect_byte(ref_m[0], "R6 wrap to zero");
    recv_byte(1, b); recv_byte(0, b);
    i2c_stop;

    // R8 locked sector 2
    lock_mask = 4'b0100;
    i2c_start; send_byte(8'hA6, a); send_byte(8'h01, a); send_byte(8'h04, a);
    send_byte(8'hC5, a);
    check(a == 0, "R8 locked data nack", a, 0);
    i2c_stop;
    repeat (10) @(negedge clk);
    check(busy == 0, "R8 no commit when locked", busy, 0);

    // R2/R8 system space is not locked
    i2c_start; send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'h04, a);
    send_byte(8'h99, a);
    check(a == 1, "R8 system write ack", a, 1);
    i2c_stop;
    ref_m[512 + 9'h104] = 8'h99;
    poll_ready(tries);

    i2c_start; send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'h04, a);
    i2c_start; send_byte(8'hAF, a);
    @(negedge clk);
    check(mem_sys == 1, "R2 system select", mem_sys, 1);
    expect_byte(8'h99, "R2 system byte");
    recv_byte(0, b);
    i2c_stop;

    i2c_start; send_byte(8'hA6, a); send_byte(8'h01, a); send_byte(8'h04, a);
    i2c_start; send_byte(8'hA7, a);
    @(negedge clk);
    check(mem_sys == 0, "R2 user select", mem_sys, 0);
    expect_byte(ref_m[9'h104], "R8 locked byte unchanged");
    recv_byte(0, b);
    i2c_stop;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0 && got_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    check(unstable == 0, "R9 sda stable while scl high", unstable, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule